// File: doc/BRIEF.md
# Firmware Health Status Checker

This block decides whether an embedded microcontroller came up healthy. It does this by reading a few of its status registers through a single register-read port. After a start pulse it reads a load-status byte once. It then samples a heartbeat byte repeatedly to see whether the firmware is still running. When both checks pass, it fetches the firmware version. The results are published together at the end of the run: two health flags, the version fields, and an enable for the wide-register access feature.

The read port has two halves. The request half is valid/ready. `rd_req_valid` stays high and `rd_req_addr` stays stable until the cycle in which `rd_req_ready` is high; the request is accepted on that cycle. At most one read is outstanding at any time. The response half has no back-pressure: the block is always able to take the single response it is waiting for. A response is one cycle of `rd_rsp_valid`, with `rd_rsp_err` and `rd_rsp_data` valid in the same cycle. Responses that arrive while no read is outstanding are dropped. The bus transport behind this port is not part of the block.

Top module: `fwh_health_check`

## Requirements
- R1: A `start` pulse while idle begins a run and raises `busy`. A `start` while `busy` is ignored: it issues no extra reads and produces no extra `done`.
- R2: `load_ok` is 1 only when the load-status byte, read at LOAD_ADDR (default 0x0100), is at least 0x0E as an unsigned value. Any smaller value gives 0.
- R3: The heartbeat check reads HB_ADDR (default 0x0104) once as a reference, then rereads it up to HB_TRIES (default 100) times. It stops at the first reread that differs from the reference, and then `heartbeat_ok` is 1. If all rereads match, `heartbeat_ok` is 0. The heartbeat check runs whatever the load result was.
- R4: The version is read only when both checks pass. It is read as four single-byte reads at VER_BASE (default 0x0200) plus 0, 1, 2 and 3, which hold major, minor, build low byte and build high byte. Otherwise `fw_major`, `fw_minor` and `fw_build` report zero.
- R5: `wide_access_en` is 1 exactly when the packed word {major, minor, build} is, as an unsigned value, at least MIN_VER. The default MIN_VER is 0x02020000, which is version 2.2.0.
- R6: A response with `rd_rsp_err` set ends the run at once. No further reads are issued, `fault` is set, and every status output keeps its previous value. `fault` is cleared by the next accepted start.
- R7: Every run, whether it completes or is aborted, ends with `done` high for exactly one cycle, and `busy` falls in that same cycle.
- R8: On the request port, `rd_req_valid` and `rd_req_addr` are held until accepted. Only one read is outstanding at a time.
- R9: Reads happen in a fixed order: the load byte first, then the heartbeat reference and rereads, then the version bytes in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a health run (pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fault | output | 1 | Last run aborted on a read error |
| load_ok | output | 1 | Load-status byte passed the threshold |
| heartbeat_ok | output | 1 | Heartbeat changed within the poll budget |
| fw_major | output | 8 | Firmware major version |
| fw_minor | output | 8 | Firmware minor version |
| fw_build | output | 16 | Firmware build number |
| wide_access_en | output | 1 | Version is at least MIN_VER |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_err | input | 1 | Read response carries an error |
| rd_rsp_data | input | 8 | Read response byte |

## Verification
The load byte is driven just below and exactly at 0x0E. This separates a greater-or-equal threshold from a strict compare and from a single-bit test. The heartbeat is made to change on the first reread, on the last allowed reread, and never. Together these separate an off-by-one poll budget from early or missing termination, and the number of reads issued is checked for each case. The version is tested around 2.2.0: for example 2.1.65535, 2.2.0 and 3.0.0. This shows that the whole packed word is compared and not a single field. Errors injected at the first read and inside the version fetch show that the earlier results are kept. Random runs that combine all of these, under random ready and latency, cover the interleavings in between. Each random run includes a stray start pulse while busy.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_HB_REF,
    S_HB_POLL,
    S_VER,
    S_COMMIT
  } step_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_REQ,
    ENG_WAIT
  } eng_t;
endpackage

// File: rtl/fwh_rd_engine.sv
module fwh_rd_engine #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              res_valid,
  output logic              res_err,
  output logic [DATA_W-1:0] res_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data
);
  import fwh_pkg::*;

  eng_t              st;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ENG_IDLE;
      addr_q    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ENG_IDLE: if (cmd_go) begin
          addr_q <= cmd_addr;
          st     <= ENG_REQ;
        end
        ENG_REQ: if (req_ready) st <= ENG_WAIT;
        ENG_WAIT: if (rsp_valid) begin
          res_valid <= 1'b1;
          res_err   <= rsp_err;
          res_data  <= rsp_data;
          st        <= ENG_IDLE;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign req_valid = (st == ENG_REQ);
  assign req_addr  = addr_q;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
endmodule

// File: rtl/fwh_ver_gate.sv
module fwh_ver_gate #(
  parameter logic [31:0] MIN_VER = 32'h0202_0000
) (
  input  logic [7:0]  major,
  input  logic [7:0]  minor,
  input  logic [15:0] build,
  output logic        at_least
);
  logic [31:0] packed_ver;
  assign packed_ver = {major, minor, build};
  assign at_least   = (packed_ver >= MIN_VER);
endmodule

// File: rtl/fwh_health_check.sv
module fwh_health_check #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] LOAD_ADDR   = 16'h0100,
  parameter logic [15:0] HB_ADDR     = 16'h0104,
  parameter logic [15:0] VER_BASE    = 16'h0200,
  parameter logic [7:0]  LOAD_THRESH = 8'h0E,
  parameter int          HB_TRIES    = 100,
  parameter logic [31:0] MIN_VER     = 32'h0202_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              load_ok,
  output logic              heartbeat_ok,
  output logic [7:0]        fw_major,
  output logic [7:0]        fw_minor,
  output logic [15:0]       fw_build,
  output logic              wide_access_en,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic              rd_rsp_err,
  input  logic [7:0]        rd_rsp_data
);
  import fwh_pkg::*;

  localparam int CNT_W = $clog2(HB_TRIES + 1);

  step_t             st;
  logic              pending;
  logic              cmd_go;
  logic [ADDR_W-1:0] cmd_addr;
  logic              res_valid, res_err;
  logic [7:0]        res_data;
  logic              load_s, hb_s;
  logic [7:0]        hb_ref;
  logic [CNT_W-1:0]  hb_cnt;
  logic [1:0]        ver_idx;
  logic [7:0]        maj_s, min_s;
  logic [15:0]       build_s;
  logic              gate_ok;

  fwh_rd_engine #(.ADDR_W(ADDR_W), .DATA_W(8)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_addr(cmd_addr),
    .res_valid(res_valid), .res_err(res_err), .res_data(res_data),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_err(rd_rsp_err), .rsp_data(rd_rsp_data)
  );

  fwh_ver_gate #(.MIN_VER(MIN_VER)) u_gate (
    .major(maj_s), .minor(min_s), .build(build_s), .at_least(gate_ok)
  );

  // Launch a read whenever a read step has none in flight.
  always_comb begin
    cmd_go = 1'b0;
    if (!pending && (st == S_LOAD || st == S_HB_REF || st == S_HB_POLL || st == S_VER))
      cmd_go = 1'b1;
    unique case (st)
      S_LOAD:             cmd_addr = ADDR_W'(LOAD_ADDR);
      S_HB_REF, S_HB_POLL: cmd_addr = ADDR_W'(HB_ADDR);
      S_VER:              cmd_addr = ADDR_W'(VER_BASE) + ADDR_W'(ver_idx);
      default:            cmd_addr = '0;
    endcase
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  pending <= 1'b0;  done <= 1'b0;  fault <= 1'b0;
      load_s <= 1'b0;  hb_s <= 1'b0;  hb_ref <= '0;  hb_cnt <= '0;  ver_idx <= '0;
      maj_s <= '0;  min_s <= '0;  build_s <= '0;
      load_ok <= 1'b0;  heartbeat_ok <= 1'b0;
      fw_major <= '0;  fw_minor <= '0;  fw_build <= '0;  wide_access_en <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_go) pending <= 1'b1;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_LOAD;  fault <= 1'b0;  pending <= 1'b0;
          load_s <= 1'b0;  hb_s <= 1'b0;  ver_idx <= '0;
          maj_s <= '0;  min_s <= '0;  build_s <= '0;
        end
      end else if (st == S_COMMIT) begin
        load_ok        <= load_s;
        heartbeat_ok   <= hb_s;
        fw_major       <= maj_s;
        fw_minor       <= min_s;
        fw_build       <= build_s;
        wide_access_en <= gate_ok;
        done           <= 1'b1;
        st             <= S_IDLE;
      end else if (res_valid) begin
        pending <= 1'b0;
        if (res_err) begin
          fault <= 1'b1;
          done  <= 1'b1;
          st    <= S_IDLE;
        end else begin
          unique case (st)
            S_LOAD: begin
              load_s <= (res_data >= LOAD_THRESH);
              st     <= S_HB_REF;
            end
            S_HB_REF: begin
              hb_ref <= res_data;
              hb_cnt <= '0;
              st     <= S_HB_POLL;
            end
            S_HB_POLL: begin
              if (res_data != hb_ref) begin
                hb_s <= 1'b1;
                st   <= load_s ? S_VER : S_COMMIT;
              end else if (hb_cnt == CNT_W'(HB_TRIES - 1)) begin
                st <= S_COMMIT;
              end else begin
                hb_cnt <= hb_cnt + 1'b1;
              end
            end
            S_VER: begin
              unique case (ver_idx)
                2'd0: maj_s <= res_data;
                2'd1: min_s <= res_data;
                2'd2: build_s[7:0] <= res_data;
                default: build_s[15:8] <= res_data;
              endcase
              ver_idx <= ver_idx + 1'b1;
              if (ver_idx == 2'd3) st <= S_COMMIT;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_start_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);

  assert_abort_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> $stable(load_ok) && $stable(heartbeat_ok) && $stable(fw_major)
                      && $stable(fw_minor) && $stable(fw_build) && $stable(wide_access_en));

  assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> done);

  assert_ver_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && heartbeat_ok) |-> fw_major == 8'd0 && fw_minor == 8'd0 && fw_build == 16'd0);

  assert_no_req_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !rd_req_valid);

  generate
    if (MIN_VER != 32'd0) begin : g_wide_chk
      assert_wide_needs_health_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wide_access_en |-> load_ok && heartbeat_ok);
    end
  endgenerate
endmodule

// File: tb/fwh_health_check_test.sv
module fwh_health_check_test;
  localparam logic [15:0] LOAD_A = 16'h0100;
  localparam logic [15:0] HB_A   = 16'h0104;
  localparam logic [15:0] VER_A  = 16'h0200;
  localparam int          TRIES  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fault, load_ok, heartbeat_ok, wide_access_en;
  logic [7:0] fw_major, fw_minor;
  logic [15:0] fw_build;
  logic rd_req_valid;
  logic rd_req_ready = 1'b0;
  logic [15:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic rd_rsp_err = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;

  always #10 clk = ~clk;

  fwh_health_check uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fault(fault),
    .load_ok(load_ok), .heartbeat_ok(heartbeat_ok), .fw_major(fw_major), .fw_minor(fw_minor),
    .fw_build(fw_build), .wide_access_en(wide_access_en),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_data(rd_rsp_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // device model state
  logic [7:0]  m_load, m_hb, m_maj, m_min;
  logic [15:0] m_build;
  int m_chg, m_err_at, m_polls;
  int rd_idx = 0;
  bit pend = 0;
  int lat = 0;
  logic [15:0] pend_addr;

  // expected published state
  logic e_load = 0, e_hb = 0, e_wide = 0;
  logic [7:0] e_maj = 0, e_min = 0;
  logic [15:0] e_build = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic f_load(input logic [7:0] v);
    return v >= 8'h0E;
  endfunction

  function automatic logic f_wide(input logic [7:0] a, input logic [7:0] b, input logic [15:0] c);
    return {a, b, c} >= 32'h0202_0000;
  endfunction

  function automatic logic [15:0] exp_addr(input int idx);
    if (idx == 0) return LOAD_A;
    if (idx <= 1 + m_polls) return HB_A;
    return VER_A + 16'(idx - 2 - m_polls);
  endfunction

  function automatic logic [7:0] model(input logic [15:0] a, input int idx);
    if (a == LOAD_A) return m_load;
    if (a == HB_A) return ((idx - 1) >= m_chg) ? m_hb + 8'd1 : m_hb;
    if (a == VER_A) return m_maj;
    if (a == VER_A + 16'd1) return m_min;
    if (a == VER_A + 16'd2) return m_build[7:0];
    if (a == VER_A + 16'd3) return m_build[15:8];
    return 8'hAA;
  endfunction

  // read responder: decides at each falling edge what the next rising edge sees
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    if (pend) begin
      if (lat == 0) begin
        rd_rsp_valid = 1'b1;
        if (rd_idx == m_err_at) begin
          rd_rsp_err  = 1'b1;
          rd_rsp_data = 8'h00;
        end else begin
          rd_rsp_data = model(pend_addr, rd_idx);
        end
        rd_idx++;
        pend = 0;
      end else lat--;
    end
    rd_req_ready = ($urandom % 4) != 0;
    if (rd_req_valid && rd_req_ready) begin
      chk(rd_req_addr == exp_addr(rd_idx), "R9 read order", rd_req_addr, exp_addr(rd_idx));
      pend = 1;
      pend_addr = rd_req_addr;
      lat = $urandom % 3;
    end
  end

  task automatic run(input logic [7:0] ld, input int chg, input logic [7:0] mj,
                     input logic [7:0] mn, input logic [15:0] bd, input int err_at,
                     input bit stray);
    bit lo, hbo, healthy;
    int nreads, exp_reads, cyc, dones;
    m_load = ld; m_chg = chg; m_maj = mj; m_min = mn; m_build = bd;
    m_err_at = err_at; m_hb = 8'($urandom);
    lo = f_load(ld);
    hbo = (chg <= TRIES);
    m_polls = hbo ? chg : TRIES;
    healthy = lo && hbo;
    nreads = 2 + m_polls + (healthy ? 4 : 0);
    rd_idx = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    dones = 0;
    cyc = 0;
    if (stray) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R1 busy before stray start", busy, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R7 done reached", done, 1);
    if (err_at < nreads) begin
      exp_reads = err_at + 1;
      chk(fault == 1'b1, "R6 fault on error", fault, 1);
    end else begin
      exp_reads = nreads;
      e_load = lo; e_hb = hbo;
      e_maj = healthy ? mj : 8'd0; e_min = healthy ? mn : 8'd0; e_build = healthy ? bd : 16'd0;
      e_wide = f_wide(e_maj, e_min, e_build);
      chk(fault == 1'b0, "R6 no fault", fault, 0);
    end
    chk(load_ok == e_load, "R2 load_ok", load_ok, e_load);
    chk(heartbeat_ok == e_hb, "R3 heartbeat_ok", heartbeat_ok, e_hb);
    chk(fw_major == e_maj && fw_minor == e_min, "R4 major/minor",
        {fw_major, fw_minor}, {e_maj, e_min});
    chk(fw_build == e_build, "R4 build", fw_build, e_build);
    chk(wide_access_en == e_wide, "R5 wide enable", wide_access_en, e_wide);
    chk(busy == 1'b0, "R7 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (4) begin @(negedge clk); if (done) dones++; end
    chk(dones == 0, "R1 no extra done", dones, 0);
    chk(rd_idx == exp_reads && !pend, "R1 R3 R6 read count", rd_idx, exp_reads);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    m_err_at = 9999; m_polls = 0; m_chg = 1;
    m_load = 0; m_hb = 0; m_maj = 0; m_min = 0; m_build = 0; pend_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fault && !load_ok && !heartbeat_ok && !wide_access_en && !rd_req_valid,
        "R7 reset state", {busy, done, fault, load_ok, heartbeat_ok, wide_access_en}, 0);
    chk(fw_major == 0 && fw_minor == 0 && fw_build == 0, "R4 reset version", fw_build, 0);

    run(8'h0E, 1, 8'd2, 8'd2, 16'd0, 9999, 0);        // R2 threshold, R5 exact boundary
    run(8'h0D, 1, 8'd5, 8'd0, 16'd9, 9999, 0);        // R2 below, R4 zeros
    run(8'hFF, 200, 8'd5, 8'd0, 16'd9, 9999, 0);      // R3 never changes
    run(8'h0F, TRIES, 8'd2, 8'd1, 16'hFFFF, 9999, 0); // R3 last reread, R5 just below
    run(8'h0E, 3, 8'd3, 8'd0, 16'd0, 9999, 1);        // R5 major dominates, R1 stray start
    run(8'h20, 2, 8'd9, 8'd9, 16'd9, 0, 0);           // R6 first read errors
    run(8'h20, 2, 8'd1, 8'd0, 16'd0, 5, 0);           // R6 error inside version fetch
    run(8'h20, 2, 8'd1, 8'd7, 16'd3, 9999, 0);        // R6 fault cleared

    for (int i = 0; i < 25; i++) begin
      run(($urandom % 2) ? 8'($urandom % 32) : 8'($urandom),
          1 + int'($urandom % 110),
          8'($urandom % 4), 8'($urandom % 4),
          ($urandom % 3 == 0) ? 16'd0 : 16'($urandom),
          ($urandom % 5 == 0) ? int'($urandom % 10) : 9999,
          1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule